// File: doc/BRIEF.md
# Shift and Unary Operation Unit with Flag Register

This unit is the single-operand part of the datapath of a small 8-bit core. Each cycle it takes one operand and an operation code. It combines them with the current carry flag and drives a result at once. It also drives a write request that tells the surrounding core whether the destination register should take that result. The core fetches the operand and owns the register file. This block only computes.

The carry (C), overflow (V) and zero (Z) flags are held in the block. So is an accumulator copy of the last result. All four update on a clock edge while the enable input is high. They are cleared by the active-low asynchronous reset. Several operations follow a zero-result carry rule: complement and increment set C when the 8-bit result is zero, not from a true carry-out. Their carry-in variants also need the incoming C to have been 1.

Operation codes on `op_i` (4 bits): 0 move, 1 move-if-carry-clear, 2 move-if-carry-set, 3 shift left, 4 shift left through carry, 5 shift right, 6 shift right through carry, 7 arithmetic shift right, 8 one's complement, 9 two's complement, 10 two's complement with carry, 11 increment, 12 increment with carry. Codes 13 to 15 are reserved.

Top module: `shift_unary_alu`

## Requirements
- R1: While `rst_ni` is low, `c_o`, `v_o`, `z_o` and `acc_o` are all 0.
- R2: Code 3 gives the operand shifted left with 0 in bit 0. Code 4 gives the same shift with the old C in bit 0. Both load the operand's bit 7 into C.
- R3: Code 5 gives the operand shifted right with 0 in bit 7. Code 6 gives the same shift with the old C in bit 7. Both load the operand's bit 0 into C.
- R4: Code 7 gives the operand shifted right with the operand's bit 7 kept in bit 7, and loads the operand's bit 0 into C.
- R5: Code 8 gives the bitwise NOT of the operand. It updates Z and the accumulator copy and keeps C and V.
- R6: Code 9 gives NOT(operand)+1 modulo 256. C becomes 1 exactly when that result is zero.
- R7: Code 10 gives NOT(operand)+C. C becomes 1 only when the result is zero and the old C was 1.
- R8: Code 11 gives operand+1 modulo 256, with C set exactly when the result is zero. Code 12 gives operand+C, with C set only when the result is zero and the old C was 1.
- R9: Codes 0, 1 and 2 give the operand as the result and change only Z and the accumulator copy. `wr_o` is always 1 for code 0. For code 1 it equals NOT C, and for code 2 it equals C.
- R10: After every enabled operation with a code from 0 to 12, Z is 1 exactly when the 8-bit result was zero, and the accumulator copy holds the result.
- R11: For codes 3 to 7 and 9 to 12, V becomes result bit 7 XOR operand bit 7. All other codes keep V.
- R12: While `en_i` is low, C, V, Z and the accumulator copy keep their values. `res_o` and `wr_o` still follow the inputs.
- R13: Codes 13 to 15 drive `wr_o` low and `res_o` equal to the operand, and change no flag and no accumulator bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Commit flags and accumulator copy at the next edge |
| op_i | input | 4 | Operation code |
| opnd_i | input | DATA_W | Operand |
| res_o | output | DATA_W | Combinational result |
| wr_o | output | 1 | Destination write request |
| acc_o | output | DATA_W | Registered accumulator copy |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |

## Verification
The bench builds the unit with the default width of 8. At that width the zero-result carry rule can be reached with operands 0x00, 0xFF and 0x01. The sign-change overflow can be reached with operands 0x40, 0x7F and 0x80. At this width the bench also sets the carry up directly, with one shift of 0x80 or 0x00, before each carry-in and conditional-move case. So both values of the incoming carry are exercised for every carry-dependent code.

// File: rtl/shift_unary_alu_pkg.sv
package shift_unary_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOV   = 4'd0,
    OP_CMVC  = 4'd1,
    OP_CMVS  = 4'd2,
    OP_SHL   = 4'd3,
    OP_SHLC  = 4'd4,
    OP_SHR   = 4'd5,
    OP_SHRC  = 4'd6,
    OP_SHRA  = 4'd7,
    OP_CPL1  = 4'd8,
    OP_CPL2  = 4'd9,
    OP_CPL2C = 4'd10,
    OP_INC   = 4'd11,
    OP_INCC  = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic c_we;
    logic c_nx;
    logic v_we;
    logic v_nx;
    logic z_we;
    logic z_nx;
  } flag_upd_t;

endpackage

// File: rtl/shift_unary_alu_shifter.sv
module shift_unary_alu_shifter
  import shift_unary_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              hit_o
);
  localparam int MSB = DATA_W - 1;

  logic              fill_lo, fill_hi, go_left;
  logic [DATA_W-1:0] left_v, right_v;

  always_comb begin
    fill_lo = (op_i == OP_SHLC) ? cin_i : 1'b0;
    unique case (op_i)
      OP_SHRC: fill_hi = cin_i;
      OP_SHRA: fill_hi = opnd_i[MSB];
      default: fill_hi = 1'b0;
    endcase
    go_left = (op_i == OP_SHL) || (op_i == OP_SHLC);
    hit_o   = go_left || (op_i == OP_SHR) || (op_i == OP_SHRC) || (op_i == OP_SHRA);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_v[i] = fill_lo;
    end else begin : g_lmid
      assign left_v[i] = opnd_i[i-1];
    end
    if (i == MSB) begin : g_hi
      assign right_v[i] = fill_hi;
    end else begin : g_rmid
      assign right_v[i] = opnd_i[i+1];
    end
  end

  assign res_o  = go_left ? left_v : right_v;
  assign cout_o = go_left ? opnd_i[MSB] : opnd_i[0];

endmodule

// File: rtl/shift_unary_alu_unary.sv
module shift_unary_alu_unary
  import shift_unary_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              c_we_o,
  output logic              hit_o
);
  logic              is_cpl, use_cin, add_bit;
  logic [DATA_W-1:0] base;

  always_comb begin
    is_cpl  = (op_i == OP_CPL1) || (op_i == OP_CPL2) || (op_i == OP_CPL2C);
    use_cin = (op_i == OP_CPL2C) || (op_i == OP_INCC);
    hit_o   = is_cpl || (op_i == OP_INC) || (op_i == OP_INCC);
    base    = is_cpl ? ~opnd_i : opnd_i;
    if (op_i == OP_CPL1) add_bit = 1'b0;
    else if (use_cin)    add_bit = cin_i;
    else                 add_bit = 1'b1;
    res_o   = base + {{(DATA_W-1){1'b0}}, add_bit};
    // carry follows a zero result, gated by old carry for carry-in variants
    cout_o  = (res_o == '0) && (use_cin ? cin_i : 1'b1);
    c_we_o  = hit_o && (op_i != OP_CPL1);
  end

endmodule

// File: rtl/shift_unary_alu_flags.sv
module shift_unary_alu_flags
  import shift_unary_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  flag_upd_t         upd_i,
  input  logic              acc_we_i,
  input  logic [DATA_W-1:0] acc_nx_i,
  output logic              c_o,
  output logic              v_o,
  output logic              z_o,
  output logic [DATA_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_o   <= 1'b0;
      v_o   <= 1'b0;
      z_o   <= 1'b0;
      acc_o <= '0;
    end else if (en_i) begin
      if (upd_i.c_we) c_o   <= upd_i.c_nx;
      if (upd_i.v_we) v_o   <= upd_i.v_nx;
      if (upd_i.z_we) z_o   <= upd_i.z_nx;
      if (acc_we_i)   acc_o <= acc_nx_i;
    end
  end

endmodule

// File: rtl/shift_unary_alu.sv
module shift_unary_alu
  import shift_unary_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              c_o,
  output logic              v_o,
  output logic              z_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] sh_res, un_res;
  logic              sh_cout, sh_hit, un_cout, un_c_we, un_hit;
  logic              is_mov, valid;
  flag_upd_t         upd;

  assign op = alu_op_e'(op_i);

  shift_unary_alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .op_i   (op),
    .opnd_i (opnd_i),
    .cin_i  (c_o),
    .res_o  (sh_res),
    .cout_o (sh_cout),
    .hit_o  (sh_hit)
  );

  shift_unary_alu_unary #(.DATA_W(DATA_W)) u_unary (
    .op_i   (op),
    .opnd_i (opnd_i),
    .cin_i  (c_o),
    .res_o  (un_res),
    .cout_o (un_cout),
    .c_we_o (un_c_we),
    .hit_o  (un_hit)
  );

  always_comb begin
    is_mov = (op == OP_MOV) || (op == OP_CMVC) || (op == OP_CMVS);
    valid  = is_mov || sh_hit || un_hit;

    if (sh_hit)      res_o = sh_res;
    else if (un_hit) res_o = un_res;
    else             res_o = opnd_i;

    unique case (op)
      OP_CMVC: wr_o = ~c_o;
      OP_CMVS: wr_o = c_o;
      default: wr_o = valid;
    endcase

    upd.c_we = sh_hit || un_c_we;
    upd.c_nx = sh_hit ? sh_cout : un_cout;
    upd.v_we = sh_hit || (un_hit && (op != OP_CPL1));
    upd.v_nx = res_o[MSB] ^ opnd_i[MSB];
    upd.z_we = valid;
    upd.z_nx = (res_o == '0);
  end

  shift_unary_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .upd_i    (upd),
    .acc_we_i (valid),
    .acc_nx_i (res_o),
    .c_o      (c_o),
    .v_o      (v_o),
    .z_o      (z_o),
    .acc_o    (acc_o)
  );

endmodule

// File: rtl/shift_unary_alu_chk.sv
module shift_unary_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              c_o,
  input logic              v_o,
  input logic              z_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (!rst_ni) begin
      a_reset_clear_r1: assert (!c_o && !v_o && !z_o && acc_o == '0);
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({c_o, v_o, z_o, acc_o}));

  p_shl_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'd3) |=> c_o == $past(opnd_i[MSB]));

  p_shr_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'd5) |=> c_o == $past(opnd_i[0]));

  p_cpl1_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'd8) |=> (c_o == $past(c_o) && v_o == $past(v_o)));

  p_inc_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'd11) |=> c_o == (acc_o == '0));

  p_cmv_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 || op_i == 4'd2) |-> wr_o == (op_i == 4'd2 ? c_o : !c_o));

  p_zero_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i <= 4'd12) |=> z_o == (acc_o == '0));

  p_reserved_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd12) |-> (!wr_o && res_o == opnd_i));

endmodule

bind shift_unary_alu shift_unary_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shift_unary_alu_test.sv
module shift_unary_alu_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opnd = 8'h00;
  logic [7:0] res, acc;
  logic       wr, c, v, z;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the flag state
  logic       mc = 0, mv = 0, mz = 0;
  logic [7:0] macc = 0;

  always #(CLK_P/2) clk = ~clk;

  shift_unary_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .opnd_i(opnd),
    .res_o(res), .wr_o(wr), .acc_o(acc), .c_o(c), .v_o(v), .z_o(z)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [7:0] x, input logic e, input string tag);
    logic [7:0] r;
    logic w, nc, nv, ok, vupd;
    @(negedge clk);
    op = o; opnd = x; en = e;
    r = x; w = 1'b1; nc = mc; nv = mv; ok = 1'b1; vupd = 1'b1;
    case (o)
      4'd0: vupd = 1'b0;
      4'd1: begin w = !mc; vupd = 1'b0; end
      4'd2: begin w = mc; vupd = 1'b0; end
      4'd3: begin r = {x[6:0], 1'b0}; nc = x[7]; end
      4'd4: begin r = {x[6:0], mc}; nc = x[7]; end
      4'd5: begin r = {1'b0, x[7:1]}; nc = x[0]; end
      4'd6: begin r = {mc, x[7:1]}; nc = x[0]; end
      4'd7: begin r = {x[7], x[7:1]}; nc = x[0]; end
      4'd8: begin r = ~x; vupd = 1'b0; end
      4'd9: begin r = ~x + 8'd1; nc = (r == 8'd0); end
      4'd10: begin r = ~x + {7'd0, mc}; nc = (r == 8'd0) && mc; end
      4'd11: begin r = x + 8'd1; nc = (r == 8'd0); end
      4'd12: begin r = x + {7'd0, mc}; nc = (r == 8'd0) && mc; end
      default: begin ok = 1'b0; w = 1'b0; vupd = 1'b0; end
    endcase
    if (vupd) nv = r[7] ^ x[7];
    #1;
    chk(tag, "res", res, r);
    chk(tag, "wr", wr, w);
    @(posedge clk);
    #1;
    if (e && ok) begin
      mc = nc; mv = nv; mz = (r == 8'd0); macc = r;
    end
    chk(tag, "c", c, mc);
    chk(tag, "v", v, mv);
    chk(tag, "z", z, mz);
    chk(tag, "acc", acc, macc);
  endtask

  task automatic set_c(input logic b);
    do_op(4'd3, {b, 7'd0}, 1'b1, "R2");
  endtask

  task automatic t_reset;
    chk("R1", "c", c, 0); chk("R1", "v", v, 0);
    chk("R1", "z", z, 0); chk("R1", "acc", acc, 0);
  endtask

  task automatic t_shift_left;
    do_op(4'd3, 8'hA5, 1'b1, "R2");
    do_op(4'd3, 8'h40, 1'b1, "R11");
    set_c(1'b1); do_op(4'd4, 8'h12, 1'b1, "R2");
    set_c(1'b0); do_op(4'd4, 8'h81, 1'b1, "R2");
    do_op(4'd3, 8'h00, 1'b1, "R10");
  endtask

  task automatic t_shift_right;
    do_op(4'd5, 8'h81, 1'b1, "R3");
    set_c(1'b1); do_op(4'd6, 8'h02, 1'b1, "R3");
    set_c(1'b0); do_op(4'd6, 8'h83, 1'b1, "R3");
    do_op(4'd5, 8'h01, 1'b1, "R10");
  endtask

  task automatic t_shift_arith;
    do_op(4'd7, 8'h81, 1'b1, "R4");
    do_op(4'd7, 8'h7E, 1'b1, "R4");
  endtask

  task automatic t_cpl1;
    set_c(1'b1); do_op(4'd3, 8'hC0, 1'b1, "R11");
    do_op(4'd8, 8'h0F, 1'b1, "R5");
    do_op(4'd8, 8'hFF, 1'b1, "R5");
  endtask

  task automatic t_cpl2;
    do_op(4'd9, 8'h00, 1'b1, "R6");
    do_op(4'd9, 8'h01, 1'b1, "R6");
    do_op(4'd9, 8'h80, 1'b1, "R11");
  endtask

  task automatic t_cpl2c;
    set_c(1'b1); do_op(4'd10, 8'hFF, 1'b1, "R7");
    set_c(1'b0); do_op(4'd10, 8'hFF, 1'b1, "R7");
    set_c(1'b1); do_op(4'd10, 8'h3C, 1'b1, "R7");
  endtask

  task automatic t_inc;
    do_op(4'd11, 8'hFF, 1'b1, "R8");
    do_op(4'd11, 8'h7F, 1'b1, "R8");
    set_c(1'b1); do_op(4'd12, 8'hFF, 1'b1, "R8");
    set_c(1'b0); do_op(4'd12, 8'h00, 1'b1, "R8");
    set_c(1'b1); do_op(4'd12, 8'h10, 1'b1, "R8");
  endtask

  task automatic t_moves;
    set_c(1'b1); do_op(4'd3, 8'hC0, 1'b1, "R11");
    do_op(4'd0, 8'h00, 1'b1, "R9");
    do_op(4'd1, 8'h5A, 1'b1, "R9");
    do_op(4'd2, 8'hA5, 1'b1, "R9");
    set_c(1'b0);
    do_op(4'd1, 8'h33, 1'b1, "R9");
    do_op(4'd2, 8'h00, 1'b1, "R9");
  endtask

  task automatic t_enable_low;
    set_c(1'b1);
    do_op(4'd11, 8'hFF, 1'b0, "R12");
    do_op(4'd5, 8'h02, 1'b0, "R12");
    do_op(4'd0, 8'h00, 1'b0, "R12");
  endtask

  task automatic t_reserved;
    do_op(4'd3, 8'hC1, 1'b1, "R2");
    do_op(4'd13, 8'h00, 1'b1, "R13");
    do_op(4'd15, 8'h7F, 1'b1, "R13");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 2);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_shift_left;
    t_shift_right;
    t_shift_arith;
    t_cpl1;
    t_cpl2;
    t_cpl2c;
    t_inc;
    t_moves;
    t_enable_low;
    t_reserved;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule